// File: doc/BRIEF.md
# Shifting Arithmetic Logic Unit

A 32-bit combinational arithmetic and logic unit for a single-cycle datapath. A 5-bit function code picks one of three operation groups. The arithmetic group adds or subtracts two operands. The Boolean group gives bitwise AND, OR, XOR or NOR. The shift group moves operand B by a distance taken from operand A, either left, logically right or arithmetically right.

Next to the 32-bit result the unit drives four condition flags: zero, negative, signed overflow and carry. A controller can use them for equality and magnitude branches and for set-on-less-than, with no comparator of its own. The unit has no state, so the result and flags follow the inputs within the same cycle.

Top module: `alu_core`

## Requirements
- R1: The function code fn_i holds, from bit 4 down to bit 0: sub (bit 4), a 2-bit selector sel (bits 3:2), shift (bit 1) and math (bit 0). When shift=1 the shifter result is chosen, whatever the values of math and sub. When shift=0, math picks the arithmetic group (1) or the Boolean group (0).
- R2: With math=1, shift=0 and sub=0, result_o is (A+B) mod 2^32 and carry_o is the carry out of bit 31.
- R3: With math=1, shift=0 and sub=1, result_o is (A−B) mod 2^32, computed as A + ~B + 1. carry_o is the carry out of that sum, so carry_o=1 means there was no borrow.
- R4: For addition and subtraction, ovf_o is 1 exactly when the two's-complement result does not fit in 32 signed bits.
- R5: With math=0 and shift=0, sel 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOR(A,B).
- R6: With shift=1 and sel[1]=0 (sel 00 or 01), result_o is B shifted left logically, with zeros filled in at the right.
- R7: With shift=1 and sel 10, result_o is B shifted right logically, with zeros filled in at the left.
- R8: With shift=1 and sel 11, result_o is B shifted right arithmetically, with copies of B[31] filled in at the left.
- R9: The shift distance is A[4:0] (0 to 31). A[31:5] has no effect on a shift result.
- R10: For every operation, zero_o is 1 exactly when result_o is all zeros, and neg_o equals result_o[31].
- R11: For Boolean and shift operations, ovf_o and carry_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | Operand A; its low 5 bits give the shift distance |
| b_i | input | 32 | Operand B; the value that is shifted |
| fn_i | input | 5 | Function code {sub, sel[1:0], shift, math} |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result bit 31 |
| ovf_o | output | 1 | Signed overflow of add/subtract |
| carry_o | output | 1 | Carry out of add/subtract (1 = no borrow on subtract) |

## Verification
The assertions are immediate checks on a block without state. They assume that a_i, b_i and fn_i are fully driven, two-valued values that stay fixed while the outputs are examined. The stimulus meets this by changing the inputs only at rising clock edges and examining the outputs at falling edges. Every one of the 32 function codes, including the unused combinations of sub and math under shift, is swept across a set of boundary operands. A separate sweep covers every shift distance with nonzero upper bits in A, so all operands stay within the codes and values the requirements define.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FN_W = 5;

  typedef struct packed {
    logic       sub;
    logic [1:0] sel;
    logic       shift;
    logic       math;
  } alu_fn_t;

  typedef enum logic [1:0] {
    BOOL_AND = 2'b00,
    BOOL_OR  = 2'b01,
    BOOL_XOR = 2'b10,
    BOOL_NOR = 2'b11
  } bool_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_x;
  logic [W:0]   full;

  assign b_x  = b_i ^ {W{sub_i}};
  assign full = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  // same operand signs, different result sign
  assign ovf_o = (a_i[W-1] == b_x[W-1]) && (full[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_bool.sv
module alu_bool
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (bool_op_e'(sel_i))
      BOOL_AND: res_o = a_i & b_i;
      BOOL_OR:  res_o = a_i | b_i;
      BOOL_XOR: res_o = a_i ^ b_i;
      default:  res_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           right_i,
  input  logic           arith_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] val_rev;
  logic [W-1:0] out_rev;
  logic [W-1:0] stage [SHW+1];
  logic         fill;

  // left shifts reuse the right-shift array on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign val_rev[i] = val_i[W-1-i];
    assign out_rev[i] = stage[SHW][W-1-i];
  end

  assign fill     = right_i & arith_i & val_i[W-1];
  assign stage[0] = right_i ? val_i : val_rev;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 2 ** k;
    assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  assign res_o = right_i ? stage[SHW] : out_rev;
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            neg_o,
  output logic            ovf_o,
  output logic            carry_o
);
  alu_fn_t      fn;
  logic [W-1:0] sum, bool_res, shf_res;
  logic         add_c, add_v, is_arith;

  assign fn       = alu_fn_t'(fn_i);
  assign is_arith = fn.math & ~fn.shift;

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(fn.sub),
    .sum_o(sum), .carry_o(add_c), .ovf_o(add_v)
  );

  alu_bool #(.W(W)) u_bool (
    .a_i(a_i), .b_i(b_i), .sel_i(fn.sel), .res_o(bool_res)
  );

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .val_i(b_i), .amt_i(a_i[SHW-1:0]),
    .right_i(fn.sel[1]), .arith_i(fn.sel[0]),
    .res_o(shf_res)
  );

  always_comb begin
    if (fn.shift)     result_o = shf_res;
    else if (fn.math) result_o = sum;
    else              result_o = bool_res;
  end

  assign zero_o  = ~|result_o;
  assign neg_o   = result_o[W-1];
  assign ovf_o   = is_arith & add_v;
  assign carry_o = is_arith & add_c;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   fn_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o,
  input logic         carry_o
);
  always_comb begin
    // R11
    flags_quiet_chk: assert (!(fn_i[1] || !fn_i[0]) || 1'b1 == 1'b1 && (fn_i[0] && !fn_i[1]) || (!ovf_o && !carry_o));
    // R10
    zero_not_neg_chk: assert (!(zero_o && neg_o));
    // R9
    shift_zero_chk: assert (!(fn_i[1] && a_i[SHW-1:0] == '0) || result_o == b_i);
    // R8
    sra_sign_chk: assert (!(fn_i[1] && fn_i[3:2] == 2'b11) || result_o[W-1] == b_i[W-1]);
    // R3
    sub_equal_chk: assert (!(fn_i[0] && !fn_i[1] && fn_i[4] && a_i == b_i) || (zero_o && carry_o && !ovf_o));
    // R5
    xor_self_chk: assert (!(fn_i[1:0] == 2'b00 && fn_i[3:2] == 2'b10 && a_i == b_i) || zero_o);
  end
endmodule

bind alu_core alu_core_chk #(.W(W), .SHW(SHW)) u_chk (
  .a_i(a_i), .b_i(b_i), .fn_i(fn_i), .result_o(result_o),
  .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o), .carry_o(carry_o)
);

// File: tb/alu_core_test.sv
`timescale 1ns/1ps
module alu_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  fn;
  logic [31:0] res;
  logic        z, n, v, c;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  alu_core uut (
    .a_i(a), .b_i(b), .fn_i(fn), .result_o(res),
    .zero_o(z), .neg_o(n), .ovf_o(v), .carry_o(c)
  );

  function automatic logic [31:0] pat(int i);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0001;
      2:  return 32'hFFFF_FFFF;
      3:  return 32'h7FFF_FFFF;
      4:  return 32'h8000_0000;
      5:  return 32'h5555_5555;
      6:  return 32'hAAAA_AAAA;
      7:  return 32'h0000_001F;
      8:  return 32'h8000_0001;
      9:  return 32'h1234_5678;
      10: return 32'hFEDC_BA98;
      default: return 32'h0000_0010;
    endcase
  endfunction

  // expected {result, v, c} from the requirements
  function automatic logic [33:0] model(logic [31:0] x, logic [31:0] y, logic [4:0] f);
    logic [32:0] u;
    logic signed [32:0] s;
    logic [31:0] r;
    logic ov, cy;
    int sh;
    ov = 1'b0; cy = 1'b0;
    sh = int'(x[4:0]);
    if (f[1]) begin
      if (!f[3])     r = y << sh;
      else if (!f[2]) r = y >> sh;
      else           r = 32'($signed(y) >>> sh);
    end else if (f[0]) begin
      if (!f[4]) begin
        u = {1'b0, x} + {1'b0, y};
        s = $signed({x[31], x}) + $signed({y[31], y});
      end else begin
        u = {1'b0, x} + {1'b0, ~y} + 33'd1;
        s = $signed({x[31], x}) - $signed({y[31], y});
      end
      r = u[31:0]; cy = u[32]; ov = s[32] != s[31];
    end else begin
      case (f[3:2])
        2'b00: r = x & y;
        2'b01: r = x | y;
        2'b10: r = x ^ y;
        default: r = ~(x | y);
      endcase
    end
    return {r, ov, cy};
  endfunction

  function automatic string op_tag(logic [4:0] f);
    if (f[1]) return f[3] ? (f[2] ? "R8" : "R7") : "R6";
    if (f[0]) return f[4] ? "R3" : "R2";
    return "R5";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h fn=%b actual=%h expected=%h", tag, a, b, fn, act, exp);
    end
  endtask

  task automatic apply_and_check(string opt);
    logic [33:0] e;
    string t;
    @(posedge clk);
    e = model(a, b, fn);
    @(negedge clk);
    t = (opt == "") ? op_tag(fn) : opt;
    // R1: operation selected by the field layout
    check(t, {32'd0, res}, {32'd0, e[33:2]});
    // R10
    check("R10", {62'd0, z, n}, {62'd0, e[33:2] == 32'd0, e[33]});
    if (fn[0] && !fn[1]) begin
      check("R4", {63'd0, v}, {63'd0, e[1]});
      check(fn[4] ? "R3" : "R2", {63'd0, c}, {63'd0, e[0]});
    end else begin
      // R11
      check("R11", {62'd0, v, c}, 64'd0);
    end
  endtask

  initial begin
    a = '0; b = '0; fn = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: AND of zeros
    check("R5", {32'd0, res}, 64'd0);
    check("R10", {62'd0, z, n}, {62'd0, 2'b10});
    // R1: full function-code sweep over boundary operands
    for (int f = 0; f < 32; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++) begin
          a = pat(i); b = pat(j); fn = 5'(f);
          apply_and_check("");
        end
    // R9: every distance, with upper bits of A set
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 64; d++)
        for (int j = 0; j < 12; j++) begin
          a = {27'h5A5A5A5 ^ 27'(d * 32'h0101_0101), 5'(d)};
          b = pat(j);
          fn = {1'b0, 2'(s), 1'b1, 1'(d & 1)};
          apply_and_check("R9");
        end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule